// File: doc/BRIEF.md
# Buffered Resource Slot Tracker

This block follows the scheduler-queue occupancy and the lock state of one execution resource in an out-of-order core model. The dispatch stage asks for a slot when an operation enters the resource's queue. Issue logic gives the slot back when the operation leaves. Separate requests lock and unlock the resource. Each cycle the block reports whether a new operation may dispatch onto the resource, and it keeps the highest occupancy seen since reset.

A single signed parameter, `BUF_SIZE`, selects the behaviour:
- `-1` gives an unlimited resource with no slot accounting.
- `0` gives a dispatch hazard. The resource locks itself at dispatch and stays locked until it is explicitly unlocked.
- `1` gives a one-entry queue, which forces in-order execution.
- Any larger value gives an out-of-order queue of that depth.

Top module: `res_slot_tracker`

## Requirements
- R1: After reset, `freeSlots` equals `BUF_SIZE` when `BUF_SIZE` > 0 and equals 0 otherwise. `peakUsed` is 0, and `reservedOut` and `dblRsvErr` are low.
- R2: The class flags are constant and are set as follows:
  - `isUnlimited` is high only for `BUF_SIZE` = -1.
  - `isHazard` is high only for 0.
  - `isInOrder` is high only for 1.
  - `isBuffered` is high for every value > 0.
- R3: `statusCode` takes one of three values, checked in this priority order:
  - 2'd2 (locked) when the resource is a hazard and `reservedOut` is high;
  - otherwise 2'd0 (available) when the resource is not buffered or `freeSlots` > 0;
  - otherwise 2'd1 (full).
- R4: A cycle with `reserveReq` high and `releaseReq` low lowers `freeSlots` by one on the next edge when it is nonzero. When it is zero, `freeSlots` stays at 0.
- R5: A cycle with `releaseReq` high and `reserveReq` low raises `freeSlots` by one only for a buffered resource, and never above `BUF_SIZE`. Otherwise the count is unchanged.
- R6: A cycle with both `reserveReq` and `releaseReq` high leaves `freeSlots` unchanged.
- R7: On every edge where `reserveReq` is high and the resource is buffered, `peakUsed` becomes the larger of its old value and `BUF_SIZE` minus the new `freeSlots`. Otherwise `peakUsed` holds, so it never decreases.
- R8: The reserved flag is updated on the next edge as follows:
  - it is set when `setRsv` is high, or when `reserveReq` is high on a hazard resource;
  - otherwise it is cleared when `clrRsv` is high;
  - otherwise it holds.
- R9: `readyOk` is high when `reservedOut` is low or when the resource is a hazard.
- R10: A cycle with `setRsv` high while `reservedOut` is already high makes `dblRsvErr` high for exactly the next cycle. In every other case `dblRsvErr` is low.
- R11: An unlimited resource keeps `freeSlots` at 0 and `statusCode` at 2'd0 under any requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reserveReq | input | 1 | Dispatch takes a queue slot |
| releaseReq | input | 1 | Issue returns a queue slot |
| setRsv | input | 1 | Lock the resource |
| clrRsv | input | 1 | Unlock the resource |
| statusCode | output | 2 | Dispatch state (see R3) |
| freeSlots | output | CW | Free queue slots |
| peakUsed | output | CW | Highest occupancy since reset |
| reservedOut | output | 1 | Lock flag |
| readyOk | output | 1 | Readiness ignoring lock on hazards |
| dblRsvErr | output | 1 | Lock requested while already locked |
| isUnlimited | output | 1 | BUF_SIZE = -1 |
| isHazard | output | 1 | BUF_SIZE = 0 |
| isInOrder | output | 1 | BUF_SIZE = 1 |
| isBuffered | output | 1 | BUF_SIZE > 0 |

CW is $clog2(max(BUF_SIZE,1)+1).

## Verification
The bench builds four copies with `BUF_SIZE` of 3, 0, 1 and -1, so every one of the four behaviours is exercised. All four copies receive the same request stream. The depth-3 copy reaches the empty, partly filled and full corners with a short random stream, which tests saturation on release and the hold at zero on reserve. The hazard and unlimited copies show self-locking at dispatch and the absence of slot accounting. The depth-1 copy toggles between its only two occupancy states.

// File: rtl/res_slot_pkg.sv
package res_slot_pkg;
  typedef enum logic [1:0] {
    ST_AVAIL  = 2'd0,
    ST_FULL   = 2'd1,
    ST_LOCKED = 2'd2
  } slot_status_e;

  typedef struct packed {
    logic dec;
    logic inc;
    logic peakEn;
  } slot_strobe_t;
endpackage

// File: rtl/res_slot_data.sv
module res_slot_data
  import res_slot_pkg::*;
#(
  parameter int SZ = 3,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  slot_strobe_t  strb,
  output logic [CW-1:0] freeQ,
  output logic [CW-1:0] peakQ,
  output logic          hasFree,
  output logic          notFull
);
  localparam logic [CW-1:0] SZ_V = CW'(SZ);

  logic [CW-1:0] freeNext;
  logic [CW-1:0] usedNext;

  always_comb begin
    freeNext = freeQ;
    if (strb.dec)      freeNext = freeQ - 1'b1;
    else if (strb.inc) freeNext = freeQ + 1'b1;
    usedNext = SZ_V - freeNext;
  end

  assign hasFree = (freeQ != '0);
  assign notFull = (freeQ < SZ_V);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeQ <= SZ_V;
      peakQ <= '0;
    end else begin
      freeQ <= freeNext;
      if (strb.peakEn && usedNext > peakQ) peakQ <= usedNext;
    end
  end

  a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |=> freeQ == $past(freeQ) - 1'b1);
  a_r5_never_above_size: assert property (@(posedge clk) disable iff (!rstN)
    freeQ <= SZ_V);
  a_r7_peak_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> peakQ >= $past(peakQ));
endmodule

// File: rtl/res_slot_ctrl.sv
module res_slot_ctrl
  import res_slot_pkg::*;
#(
  parameter int BUF_SIZE = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reserveReq,
  input  logic         releaseReq,
  input  logic         setRsv,
  input  logic         clrRsv,
  input  logic         hasFree,
  input  logic         notFull,
  output slot_strobe_t strb,
  output logic         reservedQ,
  output logic         errQ,
  output logic [1:0]   statusCode,
  output logic         readyOk
);
  localparam bit HAZARD   = (BUF_SIZE == 0);
  localparam bit BUFFERED = (BUF_SIZE > 0);

  always_comb begin
    strb.dec    = reserveReq && !releaseReq && hasFree;
    strb.inc    = releaseReq && !reserveReq && BUFFERED && notFull;
    strb.peakEn = reserveReq && BUFFERED;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reservedQ <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      errQ <= setRsv && reservedQ;
      if (setRsv || (reserveReq && HAZARD)) reservedQ <= 1'b1;
      else if (clrRsv)                      reservedQ <= 1'b0;
    end
  end

  always_comb begin
    if (HAZARD && reservedQ)        statusCode = ST_LOCKED;
    else if (!BUFFERED || hasFree)  statusCode = ST_AVAIL;
    else                            statusCode = ST_FULL;
  end

  assign readyOk = !reservedQ || HAZARD;

  a_r8_hazard_self_locks: assert property (@(posedge clk) disable iff (!rstN)
    (reserveReq && HAZARD) |=> reservedQ);
  a_r10_double_lock_flag: assert property (@(posedge clk) disable iff (!rstN)
    (setRsv && reservedQ) |=> errQ);
  a_r8_clear_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (clrRsv && !setRsv && !(reserveReq && HAZARD)) |=> !reservedQ);
endmodule

// File: rtl/res_slot_tracker.sv
module res_slot_tracker
  import res_slot_pkg::*;
#(
  parameter int BUF_SIZE = 3,
  localparam int SZ  = (BUF_SIZE > 0) ? BUF_SIZE : 0,
  localparam int SZP = (SZ < 1) ? 1 : SZ,
  localparam int CW  = $clog2(SZP + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reserveReq,
  input  logic          releaseReq,
  input  logic          setRsv,
  input  logic          clrRsv,
  output logic [1:0]    statusCode,
  output logic [CW-1:0] freeSlots,
  output logic [CW-1:0] peakUsed,
  output logic          reservedOut,
  output logic          readyOk,
  output logic          dblRsvErr,
  output logic          isUnlimited,
  output logic          isHazard,
  output logic          isInOrder,
  output logic          isBuffered
);
  slot_strobe_t strb;
  logic hasFree, notFull;

  assign isUnlimited = (BUF_SIZE == -1);
  assign isHazard    = (BUF_SIZE == 0);
  assign isInOrder   = (BUF_SIZE == 1);
  assign isBuffered  = (BUF_SIZE > 0);

  res_slot_ctrl #(.BUF_SIZE(BUF_SIZE)) uCtrl (
    .clk(clk), .rstN(rstN), .reserveReq(reserveReq), .releaseReq(releaseReq),
    .setRsv(setRsv), .clrRsv(clrRsv), .hasFree(hasFree), .notFull(notFull),
    .strb(strb), .reservedQ(reservedOut), .errQ(dblRsvErr),
    .statusCode(statusCode), .readyOk(readyOk)
  );

  res_slot_data #(.SZ(SZ), .CW(CW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .freeQ(freeSlots), .peakQ(peakUsed),
    .hasFree(hasFree), .notFull(notFull)
  );

  a_r11_unlimited_no_slots: assert property (@(posedge clk) disable iff (!rstN)
    (BUF_SIZE == -1) |-> (freeSlots == '0 && statusCode == 2'd0));
endmodule

// File: tb/sim_res_slot_tracker.sv
module sim_res_slot_tracker;
  localparam int PERIOD = 10;
  localparam int NI = 4;
  localparam int SIZES [NI] = '{3, 0, 1, -1};

  logic clk = 0, rstN = 0;
  logic reserveReq = 0, releaseReq = 0, setRsv = 0, clrRsv = 0;
  int nChk = 0, nFail = 0;
  bit done = 0;

  logic [1:0] stO [NI];
  int freeO [NI], peakO [NI];
  logic rsvO [NI], rdyO [NI], errO [NI], unlO [NI], hzO [NI], ioO [NI], bufO [NI];
  int mFree [NI], mPeak [NI];
  bit mRsv [NI], mErr [NI];

  always #(PERIOD/2) clk = ~clk;

  logic [1:0] f0, p0;
  logic f1, p1, f2, p2, f3, p3;
  res_slot_tracker #(.BUF_SIZE(3)) u0 (.clk, .rstN, .reserveReq, .releaseReq, .setRsv, .clrRsv,
    .statusCode(stO[0]), .freeSlots(f0), .peakUsed(p0), .reservedOut(rsvO[0]), .readyOk(rdyO[0]),
    .dblRsvErr(errO[0]), .isUnlimited(unlO[0]), .isHazard(hzO[0]), .isInOrder(ioO[0]), .isBuffered(bufO[0]));
  res_slot_tracker #(.BUF_SIZE(0)) u1 (.clk, .rstN, .reserveReq, .releaseReq, .setRsv, .clrRsv,
    .statusCode(stO[1]), .freeSlots(f1), .peakUsed(p1), .reservedOut(rsvO[1]), .readyOk(rdyO[1]),
    .dblRsvErr(errO[1]), .isUnlimited(unlO[1]), .isHazard(hzO[1]), .isInOrder(ioO[1]), .isBuffered(bufO[1]));
  res_slot_tracker #(.BUF_SIZE(1)) u2 (.clk, .rstN, .reserveReq, .releaseReq, .setRsv, .clrRsv,
    .statusCode(stO[2]), .freeSlots(f2), .peakUsed(p2), .reservedOut(rsvO[2]), .readyOk(rdyO[2]),
    .dblRsvErr(errO[2]), .isUnlimited(unlO[2]), .isHazard(hzO[2]), .isInOrder(ioO[2]), .isBuffered(bufO[2]));
  res_slot_tracker #(.BUF_SIZE(-1)) u3 (.clk, .rstN, .reserveReq, .releaseReq, .setRsv, .clrRsv,
    .statusCode(stO[3]), .freeSlots(f3), .peakUsed(p3), .reservedOut(rsvO[3]), .readyOk(rdyO[3]),
    .dblRsvErr(errO[3]), .isUnlimited(unlO[3]), .isHazard(hzO[3]), .isInOrder(ioO[3]), .isBuffered(bufO[3]));

  always_comb begin
    freeO[0] = int'(f0); peakO[0] = int'(p0);
    freeO[1] = int'(f1); peakO[1] = int'(p1);
    freeO[2] = int'(f2); peakO[2] = int'(p2);
    freeO[3] = int'(f3); peakO[3] = int'(p3);
  end

  task automatic chk(input string tag, input int i, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s inst %0d: actual %0d expected %0d", tag, i, act, exp);
    end
  endtask

  function automatic int expStatus(int s, bit rsv, int fr);
    if (s == 0 && rsv) return 2;
    if (s <= 0 || fr > 0) return 0;
    return 1;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NI; i++) begin
      mFree[i] = SIZES[i] > 0 ? SIZES[i] : 0;
      mPeak[i] = 0; mRsv[i] = 0; mErr[i] = 0;
    end
  endtask

  task automatic checkAll();
    for (int i = 0; i < NI; i++) begin
      chk("R4/R5/R6 freeSlots", i, freeO[i], mFree[i]);
      chk("R7 peakUsed", i, peakO[i], mPeak[i]);
      chk("R3 statusCode", i, int'(stO[i]), expStatus(SIZES[i], mRsv[i], mFree[i]));
      chk("R8 reservedOut", i, int'(rsvO[i]), int'(mRsv[i]));
      chk("R9 readyOk", i, int'(rdyO[i]), int'(!mRsv[i] || SIZES[i] == 0));
      chk("R10 dblRsvErr", i, int'(errO[i]), int'(mErr[i]));
      if (SIZES[i] == -1) chk("R11 unlimited free", i, freeO[i], 0);
    end
  endtask

  task automatic step(input bit rs, input bit rl, input bit st, input bit cl);
    reserveReq = rs; releaseReq = rl; setRsv = st; clrRsv = cl;
    for (int i = 0; i < NI; i++) begin
      int s = SIZES[i];
      mErr[i] = st && mRsv[i];
      if (st || (rs && s == 0)) mRsv[i] = 1;
      else if (cl) mRsv[i] = 0;
      if (rs && !rl) begin
        if (mFree[i] > 0) mFree[i]--;
      end else if (rl && !rs && s > 0 && mFree[i] < s) mFree[i]++;
      if (rs && s > 0 && (s - mFree[i]) > mPeak[i]) mPeak[i] = s - mFree[i];
    end
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < NI; i++) begin
      chk("R1 free after reset", i, freeO[i], mFree[i]);
      chk("R1 peak after reset", i, peakO[i], 0);
      chk("R1 reserved after reset", i, int'(rsvO[i]), 0);
      chk("R1 err after reset", i, int'(errO[i]), 0);
      // R2: class flags
      chk("R2 isUnlimited", i, int'(unlO[i]), int'(SIZES[i] == -1));
      chk("R2 isHazard", i, int'(hzO[i]), int'(SIZES[i] == 0));
      chk("R2 isInOrder", i, int'(ioO[i]), int'(SIZES[i] == 1));
      chk("R2 isBuffered", i, int'(bufO[i]), int'(SIZES[i] > 0));
    end
    // R5: release when already full saturates
    step(0, 1, 0, 0);
    // R4: drain past zero, then reserve at zero holds
    repeat (5) step(1, 0, 0, 0);
    // R6: simultaneous reserve and release
    step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    step(1, 1, 0, 0);
    // R8/R10: lock, double lock, clear
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    step(0, 0, 0, 1);
    // refill R5
    repeat (4) step(0, 1, 0, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit rs = ($urandom % 100) < 45;
      bit rl = ($urandom % 100) < 40;
      bit st = ($urandom % 100) < 8;
      bit cl = ($urandom % 100) < 20;
      step(rs, rl, st, cl);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule